// File: doc/BRIEF.md
# SPI Host Character Controller

This block is the host side of a four-wire SPI link. Software-facing logic writes a 32-bit control word and then feeds characters one at a time into a transmit holding register. The block moves each character into a shifter, clocks it out MSB first on `mosi` with a serial clock that idles low (data changes on the falling edge and is sampled on the rising edge), and captures the same number of bits from `miso` into a receive register. Characters are 8 to 16 bits long.

A single active-low chip select frames the traffic. Whether it is released after a character depends on a policy field in the control word. It can be released when no further character is waiting, only after a character tagged as last, or after every character. Two delay fields, both counted in system-clock cycles, add a gap between characters that share one chip-select assertion and set a minimum high time on the chip select. An internal loopback routes the outgoing bit stream into the receiver. A stall option stops the next character from starting while received data has not been collected.

The controller is a six-state machine. `ST_IDLE` (chip select high) goes to `ST_LOAD` when a character is waiting and no stall applies. `ST_LOAD` copies the holding register into the shifter and goes to `ST_SHIFT`. When the last bit ends, `ST_SHIFT` goes to `ST_HOLD`, or straight to `ST_IDLE` if the idle delay is zero, when the release policy fires. Otherwise it goes to `ST_GAP`, or straight to `ST_WAIT` if the gap is zero. `ST_GAP` goes to `ST_WAIT` when its count runs out. `ST_WAIT` (chip select still low) goes to `ST_LOAD` when a character is waiting and no stall applies. `ST_HOLD` goes to `ST_IDLE` when the idle count runs out.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset `cs_n`=1, `sck`=0, `mosi`=0, `txd_empty`=1, `rxd_full`=0 and `busy`=0. The control word is zero, which selects 8-bit characters, policy 0 and no delays.
- R2: Control word fields: bit 1 is loopback, bit 2 is stall-on-unread, bits 5:4 are the release policy, bits 11:8 are the length code, bits 23:16 are the gap count and bits 31:24 are the idle count. Bits 0 and 3 have no effect on the transfer.
- R3: A length code c from 0 to 8 gives c+8 bits per character. Codes 9 to 15 give 16 bits. Exactly that many `sck` pulses occur per character, and the low bits of the written word go out MSB first.
- R4: `sck` is low whenever `cs_n` is high. Each `sck` high phase lasts `SCK_HALF_DIV` system cycles. `miso` is sampled on the rising edge.
- R5: When a character ends, `rxd_data` holds the received bits right-aligned with zeros above them, and `rxd_full` goes to 1. A pulse on `rxd_re` clears `rxd_full`.
- R6: Policy 0: if a new character was written before the current one ended, `cs_n` stays low into the next character. Otherwise `cs_n` rises after the current one.
- R7: Policy 1: `cs_n` stays low after a character written with `txd_last`=0, even with nothing queued. It rises after a character written with `txd_last`=1.
- R8: Policies 2 and 3 release `cs_n` after every character.
- R9: Between two characters in one chip-select assertion, `sck` stays low for at least gap + `SCK_HALF_DIV` cycles.
- R10: Once released, `cs_n` stays high for at least the idle count of cycles before it falls again.
- R11: With loopback set, the received character equals the transmitted one and `miso` is ignored.
- R12: With stall-on-unread set and `rxd_full`=1, no character starts: `cs_n` stays high, `rxd_data` is kept and `txd_empty` stays 0 until `rxd_re`.
- R13: `txd_empty` goes to 0 the cycle after a write and returns to 1 once the character has moved into the shifter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 32 | Control word value |
| txd_we | input | 1 | Transmit holding register write strobe |
| txd_wdata | input | 16 | Character to send, right-aligned |
| txd_last | input | 1 | Marks the written character as last (policy 1) |
| rxd_re | input | 1 | Receive data read strobe, clears `rxd_full` |
| rxd_data | output | 16 | Last received character, right-aligned |
| rxd_full | output | 1 | Receive register holds unread data |
| txd_empty | output | 1 | Transmit holding register is free |
| busy | output | 1 | Controller is not in `ST_IDLE` |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the device |
| miso | input | 1 | Serial data from the device |
| cs_n | output | 1 | Active-low chip select |

## Verification
The hardest situation to reach is a second character that is already waiting in the holding register at the exact moment the first one finishes. That is the only case where policy 0 keeps the chip select low and where the gap counter runs. The stimulus gets there by polling for the chip-select fall of the first character and writing the second character during its shift phase. The stall case is also hard to reach, because software has to leave received data unread and queue another character. The bench skips the read on purpose and then watches the pins for many cycles before it reads.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

    localparam int CTL_W     = 32;
    localparam int CHAR_W    = 16;
    localparam int NBITS_W   = $clog2(CHAR_W + 1);
    localparam int DLY_W     = 8;
    localparam int LEN_MIN   = 8;
    localparam int LEN_CODES = CHAR_W - LEN_MIN;

    localparam int F_LOOP    = 1;
    localparam int F_STALL   = 2;
    localparam int F_POL_LO  = 4;
    localparam int F_LEN_LO  = 8;
    localparam int F_GAP_LO  = 16;
    localparam int F_IDLE_LO = 24;

    typedef enum logic [1:0] {
        CSP_UNDERRUN = 2'd0,
        CSP_LAST     = 2'd1,
        CSP_EACH     = 2'd2,
        CSP_SPARE    = 2'd3
    } cs_policy_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP,
        ST_WAIT,
        ST_HOLD
    } host_state_e;

    typedef struct packed {
        logic               loop_en;
        logic               stall_en;
        cs_policy_e         cs_pol;
        logic [NBITS_W-1:0] nbits;
        logic [DLY_W-1:0]   gap_cyc;
        logic [DLY_W-1:0]   idle_cyc;
    } host_cfg_t;

    function automatic host_cfg_t cfg_decode(input logic [CTL_W-1:0] w);
        host_cfg_t  c;
        logic [3:0] code;
        logic [1:0] pol;
        code       = w[F_LEN_LO +: 4];
        pol        = w[F_POL_LO +: 2];
        c.loop_en  = w[F_LOOP];
        c.stall_en = w[F_STALL];
        c.cs_pol   = (pol == CSP_SPARE) ? CSP_EACH : cs_policy_e'(pol);
        c.nbits    = (code > 4'(LEN_CODES)) ? NBITS_W'(CHAR_W)
                                            : NBITS_W'(code) + NBITS_W'(LEN_MIN);
        c.gap_cyc  = w[F_GAP_LO +: DLY_W];
        c.idle_cyc = w[F_IDLE_LO +: DLY_W];
        return c;
    endfunction

endpackage

// File: rtl/spi_host_cfg.sv
module spi_host_cfg
    import spi_host_pkg::*;
#(
    parameter int WORD_W = CTL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output host_cfg_t         cfg
);

    logic [WORD_W-1:0] word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (we) begin
            word_q <= wdata;
        end
    end

    assign cfg = cfg_decode(CTL_W'(word_q));

endmodule

// File: rtl/spi_host_dly.sv
module spi_host_dly #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last = (cnt_q <= CNT_W'(1));

    a_r9_count_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q < $past(cnt_q)));

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
    parameter int MAX_BITS = 16,
    parameter int HALF_DIV = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic                          run,
    input  logic [$clog2(MAX_BITS+1)-1:0] nbits,
    input  logic [MAX_BITS-1:0]           tx_word,
    input  logic                          loop_en,
    input  logic                          miso,
    output logic                          sck,
    output logic                          mosi,
    output logic                          done,
    output logic [MAX_BITS-1:0]           rx_word
);

    localparam int BIT_W = $clog2(MAX_BITS + 1);
    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_DIV - 1);

    logic [MAX_BITS-1:0] tx_sr;
    logic [MAX_BITS-1:0] rx_sr;
    logic [DIV_W-1:0]    div_cnt;
    logic [BIT_W-1:0]    bit_cnt;
    logic                sck_q;
    logic                sin;
    logic                phase_end;

    assign phase_end = run && (div_cnt == DIV_END);
    assign sin       = loop_en ? tx_sr[MAX_BITS-1] : miso;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr   <= '0;
            rx_sr   <= '0;
            div_cnt <= '0;
            bit_cnt <= '0;
            sck_q   <= 1'b0;
        end else if (start) begin
            tx_sr   <= tx_word << (BIT_W'(MAX_BITS) - nbits);
            rx_sr   <= '0;
            div_cnt <= '0;
            bit_cnt <= '0;
            sck_q   <= 1'b0;
        end else if (run) begin
            if (phase_end) begin
                div_cnt <= '0;
                if (!sck_q) begin
                    sck_q   <= 1'b1;
                    rx_sr   <= {rx_sr[MAX_BITS-2:0], sin};
                    bit_cnt <= bit_cnt + 1'b1;
                end else begin
                    sck_q <= 1'b0;
                    tx_sr <= tx_sr << 1;
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end else begin
            sck_q   <= 1'b0;
            div_cnt <= '0;
        end
    end

    assign sck     = sck_q;
    assign mosi    = run ? tx_sr[MAX_BITS-1] : 1'b0;
    assign done    = phase_end && sck_q && (bit_cnt == nbits);
    assign rx_word = rx_sr;

    a_r3_bit_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bit_cnt <= nbits));

    a_r4_rise_counts_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !start && $rose(sck_q)) |-> (bit_cnt != '0));

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
    import spi_host_pkg::*;
#(
    parameter int SCK_HALF_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              txd_we,
    input  logic [CHAR_W-1:0] txd_wdata,
    input  logic              txd_last,
    input  logic              rxd_re,
    output logic [CHAR_W-1:0] rxd_data,
    output logic              rxd_full,
    output logic              txd_empty,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    host_cfg_t     cfg;
    host_state_e   state_q, state_d;

    logic [CHAR_W-1:0] thr_q;
    logic              thr_full_q;
    logic              thr_last_q;
    logic              cur_last_q;
    logic [CHAR_W-1:0] rx_q;
    logic              rx_full_q;

    logic              eng_start, eng_run, eng_done;
    logic [CHAR_W-1:0] eng_rx;
    logic              stall, release_cs, can_start;
    logic              gap_load, idle_load, gap_last, idle_last;

    spi_host_cfg #(.WORD_W(CTL_W)) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .cfg   (cfg)
    );

    spi_host_shifter #(.MAX_BITS(CHAR_W), .HALF_DIV(SCK_HALF_DIV)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .run     (eng_run),
        .nbits   (cfg.nbits),
        .tx_word (thr_q),
        .loop_en (cfg.loop_en),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .done    (eng_done),
        .rx_word (eng_rx)
    );

    spi_host_dly #(.CNT_W(DLY_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (cfg.gap_cyc),
        .last     (gap_last)
    );

    spi_host_dly #(.CNT_W(DLY_W)) u_idle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idle_load),
        .load_val (cfg.idle_cyc),
        .last     (idle_last)
    );

    // Release decision taken in the cycle the last bit ends.
    always_comb begin
        unique case (cfg.cs_pol)
            CSP_UNDERRUN: release_cs = !thr_full_q;
            CSP_LAST:     release_cs = cur_last_q;
            default:      release_cs = 1'b1;
        endcase
    end

    assign stall     = cfg.stall_en && rx_full_q;
    assign can_start = thr_full_q && !stall;
    assign gap_load  = eng_done && !release_cs;
    assign idle_load = eng_done && release_cs;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (can_start) state_d = ST_LOAD;
            ST_LOAD:  state_d = ST_SHIFT;
            ST_SHIFT: begin
                if (eng_done) begin
                    if (release_cs) begin
                        state_d = (cfg.idle_cyc != '0) ? ST_HOLD : ST_IDLE;
                    end else begin
                        state_d = (cfg.gap_cyc != '0) ? ST_GAP : ST_WAIT;
                    end
                end
            end
            ST_GAP:   if (gap_last) state_d = ST_WAIT;
            ST_WAIT:  if (can_start) state_d = ST_LOAD;
            ST_HOLD:  if (idle_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        cs_n      = 1'b1;
        busy      = 1'b1;
        eng_start = 1'b0;
        eng_run   = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_LOAD:  begin cs_n = 1'b0; eng_start = 1'b1; end
            ST_SHIFT: begin cs_n = 1'b0; eng_run = 1'b1; end
            ST_GAP:   cs_n = 1'b0;
            ST_WAIT:  cs_n = 1'b0;
            ST_HOLD:  cs_n = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    // Holding and receive registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thr_q      <= '0;
            thr_full_q <= 1'b0;
            thr_last_q <= 1'b0;
            cur_last_q <= 1'b0;
            rx_q       <= '0;
            rx_full_q  <= 1'b0;
        end else begin
            if (state_q == ST_LOAD) begin
                cur_last_q <= thr_last_q;
            end
            if (txd_we) begin
                thr_q      <= txd_wdata;
                thr_full_q <= 1'b1;
                thr_last_q <= txd_last;
            end else if (state_q == ST_LOAD) begin
                thr_full_q <= 1'b0;
            end
            if (eng_done) begin
                rx_q      <= eng_rx;
                rx_full_q <= 1'b1;
            end else if (rxd_re) begin
                rx_full_q <= 1'b0;
            end
        end
    end

    assign rxd_data  = rx_q;
    assign rxd_full  = rx_full_q;
    assign txd_empty = !thr_full_q;

    a_r4_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r5_rx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> rxd_full);

    a_r7_hold_until_last: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && cfg.cs_pol == CSP_LAST && !cur_last_q) |=> !cs_n);

    a_r8_release_each: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_done && cfg.cs_pol == CSP_EACH) |=> cs_n);

    a_r12_stall_keeps_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.stall_en && rxd_full && cs_n) |=> cs_n);

    a_r13_handoff_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD && !txd_we) |=> txd_empty);

endmodule

// File: tb/spi_host_ctrl_test.sv
module spi_host_ctrl_test;

    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic        txd_we = 1'b0;
    logic [15:0] txd_wdata = '0;
    logic        txd_last = 1'b0;
    logic        rxd_re = 1'b0;
    logic [15:0] rxd_data;
    logic        rxd_full, txd_empty, busy, sck, mosi, cs_n;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_host_ctrl #(.SCK_HALF_DIV(HALF)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .txd_we(txd_we), .txd_wdata(txd_wdata), .txd_last(txd_last),
        .rxd_re(rxd_re), .rxd_data(rxd_data), .rxd_full(rxd_full),
        .txd_empty(txd_empty), .busy(busy), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int len_of(input int code);
        return (code <= 8) ? code + 8 : 16;
    endfunction

    function automatic logic miso_bit(input int i);
        logic [31:0] h;
        h = i * 32'h9E37_79B1;
        return h[17] ^ h[5];
    endfunction

    function automatic logic [31:0] ctl_word(input int loop, input int stl, input int pol,
                                             input int code, input int gap, input int idle,
                                             input int b0, input int b3);
        logic [31:0] w;
        w = '0;
        w[0]     = b0[0];
        w[1]     = loop[0];
        w[2]     = stl[0];
        w[3]     = b3[0];
        w[5:4]   = pol[1:0];
        w[11:8]  = code[3:0];
        w[23:16] = gap[7:0];
        w[31:24] = idle[7:0];
        return w;
    endfunction

    // Device model and bit monitor
    int          bitpos = 0;
    logic [31:0] mon_tx = '0;
    logic [31:0] mon_rx = '0;
    int          mon_n = 0;

    always @(negedge sck) begin
        bitpos++;
        miso <= miso_bit(bitpos);
    end

    always @(posedge sck) begin
        mon_tx = {mon_tx[30:0], mosi};
        mon_rx = {mon_rx[30:0], miso};
        mon_n++;
    end

    // Pin timing monitors, sampled mid-cycle
    int   cyc = 0;
    int   cs_hi_run = 0, last_cs_hi = 0, cs_rises = 0;
    int   sck_lo_run = 0, max_sck_lo = 0, sck_hi_run = 0, last_sck_hi = 0;
    logic cs_prev = 1'b1, sck_prev = 1'b0;
    bit   finished = 0;

    always @(negedge clk) begin
        cyc++;
        if (cs_n) cs_hi_run++;
        else begin
            if (cs_prev) last_cs_hi = cs_hi_run;
            cs_hi_run = 0;
        end
        if (cs_n && !cs_prev) cs_rises++;
        if (cs_n) sck_lo_run = 0;
        else if (!sck) sck_lo_run++;
        else if (!sck_prev) begin
            if (sck_lo_run > max_sck_lo) max_sck_lo = sck_lo_run;
            sck_lo_run = 0;
        end
        if (sck) sck_hi_run++;
        else if (sck_prev) begin
            last_sck_hi = sck_hi_run;
            sck_hi_run = 0;
        end
        cs_prev = cs_n;
        sck_prev = sck;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic ctl(input logic [31:0] w);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = w;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    task automatic send(input logic [15:0] d, input bit last);
        @(negedge clk); txd_we = 1'b1; txd_wdata = d; txd_last = last;
        @(negedge clk); txd_we = 1'b0; txd_last = 1'b0;
    endtask

    task automatic rd();
        rxd_re = 1'b1;
        @(negedge clk);
        rxd_re = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_char(input logic [15:0] d, input int len, input bit loop,
                              input bit do_read, input string tag);
        int          t;
        logic [15:0] mask, exp_tx, exp_rx;
        t = 0;
        while (!rxd_full && t < 5000) begin
            @(negedge clk);
            t++;
        end
        mask   = 16'((32'h1 << len) - 1);
        exp_tx = d & mask;
        exp_rx = loop ? exp_tx : (mon_rx[15:0] & mask);
        chk(rxd_full == 1'b1, {tag, " R5 rx flag"}, int'(rxd_full), 1);
        chk(mon_n == len, {tag, " R3 sck pulses"}, mon_n, len);
        chk((mon_tx[15:0] & mask) == exp_tx, {tag, " R3 mosi bits"},
            int'(mon_tx[15:0] & mask), int'(exp_tx));
        chk(rxd_data == exp_rx, {tag, " R5 rx data"}, int'(rxd_data), int'(exp_rx));
        mon_n = 0;
        if (do_read) rd();
    endtask

    initial begin
        int rises0;
        void'($urandom(32'd4242));
        wait_cycles(4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sck == 1'b0 && mosi == 1'b0, "R1 sck/mosi", int'({sck, mosi}), 0);
        chk(txd_empty == 1'b1 && rxd_full == 1'b0 && busy == 1'b0, "R1 flags",
            int'({txd_empty, rxd_full, busy}), 4);

        // Default word: 8 bits, policy 0, lone character releases (R6)
        mon_n = 0;
        send(16'h12A5, 1'b0);
        chk(txd_empty == 1'b0, "R13 full after write", int'(txd_empty), 0);
        check_char(16'h12A5, 8, 1'b0, 1'b1, "default");
        chk(txd_empty == 1'b1, "R13 empty after hand-off", int'(txd_empty), 1);
        chk(last_sck_hi == HALF, "R4 sck high phase", last_sck_hi, HALF);
        wait_cycles(3);
        chk(cs_n == 1'b1, "R6 release when nothing queued", int'(cs_n), 1);

        // R2 R3 R11: random lengths, loopback, ignored bits 0 and 3
        for (int i = 0; i < 14; i++) begin
            int code, loop;
            logic [15:0] d;
            code = (i < 2) ? 9 + i : int'($urandom % 16);
            loop = int'($urandom % 2);
            d = 16'($urandom);
            ctl(ctl_word(loop, 0, 2 + int'($urandom % 2), code, int'($urandom % 4),
                         int'($urandom % 4), int'($urandom % 2), int'($urandom % 2)));
            mon_n = 0;
            send(d, 1'b0);
            check_char(d, len_of(code), loop[0], 1'b1,
                       loop[0] ? "R2 R11 random loopback" : "R2 random");
        end

        // R6 R9: policy 0 with a queued second character and a gap of 12
        ctl(ctl_word(0, 0, 0, 2, 12, 0, 0, 0));
        wait_cycles(4);
        mon_n = 0;
        max_sck_lo = 0;
        rises0 = cs_rises;
        send(16'h0155, 1'b0);
        while (cs_n) @(negedge clk);
        send(16'h02AA, 1'b0);
        check_char(16'h0155, 10, 1'b0, 1'b1, "R6 first");
        check_char(16'h02AA, 10, 1'b0, 1'b1, "R6 second");
        chk(max_sck_lo >= 12 + HALF, "R9 gap between characters", max_sck_lo, 12 + HALF);
        wait_cycles(4);
        chk(cs_rises - rises0 == 1, "R6 one release for two queued", cs_rises - rises0, 1);
        chk(cs_n == 1'b1, "R6 released at underrun", int'(cs_n), 1);

        // R7: policy 1 holds until a last character
        ctl(ctl_word(0, 0, 1, 0, 0, 0, 0, 0));
        mon_n = 0;
        send(16'h00C3, 1'b0);
        check_char(16'h00C3, 8, 1'b0, 1'b1, "R7 not last");
        wait_cycles(30);
        chk(cs_n == 1'b0, "R7 held without last", int'(cs_n), 0);
        send(16'h003C, 1'b1);
        check_char(16'h003C, 8, 1'b0, 1'b1, "R7 last");
        wait_cycles(4);
        chk(cs_n == 1'b1, "R7 released after last", int'(cs_n), 1);

        // R8 R10: spare policy 3 behaves like every-character, idle 25
        ctl(ctl_word(0, 0, 3, 8, 0, 25, 0, 0));
        wait_cycles(4);
        mon_n = 0;
        rises0 = cs_rises;
        send(16'hBEEF, 1'b0);
        send(16'h1234, 1'b0);
        check_char(16'hBEEF, 16, 1'b0, 1'b1, "R8 first");
        check_char(16'h1234, 16, 1'b0, 1'b1, "R8 second");
        wait_cycles(40);
        chk(cs_rises - rises0 == 2, "R8 release per character", cs_rises - rises0, 2);
        chk(last_cs_hi >= 25, "R10 minimum chip-select high", last_cs_hi, 25);

        // R12: stall while received data is unread
        ctl(ctl_word(0, 1, 2, 0, 0, 0, 0, 0));
        mon_n = 0;
        send(16'h005A, 1'b0);
        check_char(16'h005A, 8, 1'b0, 1'b0, "R12 first");
        begin
            logic [15:0] held;
            held = rxd_data;
            send(16'h00A5, 1'b0);
            wait_cycles(60);
            chk(cs_n == 1'b1, "R12 no start while unread", int'(cs_n), 1);
            chk(rxd_data == held, "R12 rx kept", int'(rxd_data), int'(held));
            chk(txd_empty == 1'b0, "R12 char still queued", int'(txd_empty), 0);
        end
        rd();
        chk(rxd_full == 1'b0, "R5 read clears flag", int'(rxd_full), 0);
        check_char(16'h00A5, 8, 1'b0, 1'b1, "R12 after read");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule